// File: doc/BRIEF.md
# SPI Register-Access Host Controller

This block is an SPI master that carries out one register access at a time against a small register-mapped SPI peripheral. A local requester raises a one-cycle start strobe together with a direction flag, a 7-bit register address and a write byte. The controller then builds a 16-bit frame, lowers chip select, and clocks the frame out on MOSI in SPI mode 0. It samples MISO on every bit and, for a read, hands back the returned byte together with a one-cycle done pulse.

All serial timing comes from the system clock. The SCK half-period and a chip-select guard interval are parameters counted in system clocks. The same guard interval separates chip-select fall from the first SCK rise, and it separates the last SCK fall from chip-select rise. An idle gap twice as long follows every frame, so the peripheral has time to commit a write before the next request is accepted. While a frame or its gap is in progress the block reports busy, and any start strobe it sees in that time is dropped.

Top module: `spi_reg_host`

## Requirements
- R1: The frame is 16 bits, sent most-significant bit first. Bit 15 is the direction (1 = read, 0 = write), bits 14:8 are the register address, and bits 7:0 are the write byte.
- R2: SCK is low whenever chip select is high. MOSI never changes while SCK is high; it changes only at an SCK fall or while SCK is low.
- R3: Chip select falls while SCK is low and MOSI already carries frame bit 15. The first SCK rise comes SETUP_CLKS system clocks after the chip-select fall.
- R4: Each frame has exactly 16 SCK rising edges. Every SCK high phase and every low phase between rises lasts HALF_CLKS system clocks.
- R5: Chip select rises SETUP_CLKS clocks after the sixteenth SCK fall. MOSI returns to 0 in the same cycle.
- R6: done pulses high for exactly one cycle, 2*SETUP_CLKS clocks after chip select rises. busy is low in that cycle, and a start strobe is accepted from then on.
- R7: MISO is sampled in the first system clock after each SCK rise and shifted in MSB first. A read returns the last 8 sampled bits; the first 8 are discarded.
- R8: rdata changes only in the done cycle of a read. A write transaction leaves rdata unchanged.
- R9: A start strobe that arrives while busy is high is ignored. It produces no extra frame and does not alter the frame in progress.
- R10: While the synchronous active-high reset is held, and right after it is released, the outputs are: cs_n high, SCK low, MOSI low, busy low, done low, rdata zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request strobe |
| req_read | input | 1 | 1 = read access, 0 = write access |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Frame or idle gap in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by the last read |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The checker assumes three things about the inputs:
- Reset is applied synchronously.
- MISO is settled by the cycle after an SCK rise.
- start is a single-cycle strobe.

The bench keeps to these assumptions in two ways. It drives every request input on the falling system-clock edge. Its peripheral model changes MISO only at chip-select fall and at SCK falls, so MISO is never in motion when the controller samples it. The model also captures MOSI on SCK rises, so the bench compares the frame the peripheral actually received against the expected frame. A start strobe is deliberately injected in the middle of a frame to exercise the busy case.

// File: rtl/spi_rh_pkg.sv
`timescale 1ns/1ps
package spi_rh_pkg;
  localparam int FRAME_BITS = 16;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_HOLD,
    ST_GAP
  } rh_state_e;
endpackage

// File: rtl/spi_rh_timer.sv
`timescale 1ns/1ps
// Interval counter: a load starts an interval of len cycles.
// expire is high in the last cycle of the interval.
// fresh is high in the first cycle after a load.
module spi_rh_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          expire,
  output logic          fresh
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      fresh <= 1'b0;
    end else begin
      fresh <= load;
      if (load)
        cnt_q <= len - TW'(1);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - TW'(1);
    end
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/spi_rh_shifter.sv
`timescale 1ns/1ps
// Transmit and receive shift registers for one frame.
module spi_rh_shifter #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FW-1:0] frame,
  input  logic          shift,
  input  logic          capture,
  input  logic          miso,
  output logic          tx_next,
  output logic [FW-1:0] rx_word
);
  logic [FW-1:0] tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q    <= '0;
      rx_word <= '0;
    end else begin
      if (load)
        tx_q <= frame;
      else if (shift)
        tx_q <= {tx_q[FW-2:0], 1'b0};

      if (load)
        rx_word <= '0;
      else if (capture)
        rx_word <= {rx_word[FW-2:0], miso};
    end
  end

  assign tx_next = tx_q[FW-2];
endmodule

// File: rtl/spi_reg_host.sv
`timescale 1ns/1ps
module spi_reg_host
  import spi_rh_pkg::*;
#(
  parameter int HALF_CLKS  = 2,
  parameter int SETUP_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              req_read,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              cs_n,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam int MAXLEN = (2 * SETUP_CLKS > HALF_CLKS) ? 2 * SETUP_CLKS : HALF_CLKS;
  localparam int TW     = $clog2(MAXLEN + 1);
  localparam int BW     = $clog2(FRAME_BITS);

  rh_state_e       state_q;
  logic [BW-1:0]   bit_q;
  logic            is_read_q;
  logic            t_load, t_expire, t_fresh;
  logic [TW-1:0]   t_len;
  logic            tx_next;
  logic [FRAME_BITS-1:0] rx_word;
  logic [FRAME_BITS-1:0] frame;
  logic            accept;

  assign frame  = {req_read, req_addr, req_wdata};
  assign accept = (state_q == ST_IDLE) && start;

  // Interval selection for the next phase
  always_comb begin
    t_load = 1'b0;
    t_len  = TW'(HALF_CLKS);
    unique case (state_q)
      ST_IDLE:  begin t_load = start;    t_len = TW'(SETUP_CLKS); end
      ST_SETUP: begin t_load = t_expire; t_len = TW'(HALF_CLKS);  end
      ST_HIGH:  begin
        t_load = t_expire;
        t_len  = (bit_q == '0) ? TW'(SETUP_CLKS) : TW'(HALF_CLKS);
      end
      ST_LOW:   begin t_load = t_expire; t_len = TW'(HALF_CLKS);  end
      ST_HOLD:  begin t_load = t_expire; t_len = TW'(2 * SETUP_CLKS); end
      default:  begin t_load = 1'b0;     t_len = TW'(HALF_CLKS);  end
    endcase
  end

  spi_rh_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (t_load),
    .len    (t_len),
    .expire (t_expire),
    .fresh  (t_fresh)
  );

  spi_rh_shifter #(.FW(FRAME_BITS)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .frame   (frame),
    .shift   ((state_q == ST_HIGH) && t_expire && (bit_q != '0)),
    .capture ((state_q == ST_HIGH) && t_fresh),
    .miso    (miso),
    .tx_next (tx_next),
    .rx_word (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      bit_q     <= BW'(FRAME_BITS - 1);
      is_read_q <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rdata     <= '0;
      cs_n      <= 1'b1;
      sck       <= 1'b0;
      mosi      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q   <= ST_SETUP;
          bit_q     <= BW'(FRAME_BITS - 1);
          is_read_q <= req_read;
          busy      <= 1'b1;
          cs_n      <= 1'b0;
          sck       <= 1'b0;
          mosi      <= frame[FRAME_BITS-1];
        end
        ST_SETUP: if (t_expire) begin
          sck     <= 1'b1;
          state_q <= ST_HIGH;
        end
        ST_HIGH: if (t_expire) begin
          sck <= 1'b0;
          if (bit_q == '0) begin
            state_q <= ST_HOLD;
          end else begin
            state_q <= ST_LOW;
            bit_q   <= bit_q - BW'(1);
            mosi    <= tx_next;
          end
        end
        ST_LOW: if (t_expire) begin
          sck     <= 1'b1;
          state_q <= ST_HIGH;
        end
        ST_HOLD: if (t_expire) begin
          cs_n    <= 1'b1;
          mosi    <= 1'b0;
          state_q <= ST_GAP;
        end
        ST_GAP: if (t_expire) begin
          state_q <= ST_IDLE;
          busy    <= 1'b0;
          done    <= 1'b1;
          if (is_read_q)
            rdata <= rx_word[DATA_W-1:0];
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_reg_host_chk.sv
`timescale 1ns/1ps
module spi_reg_host_chk #(
  parameter int HALF_CLKS  = 2,
  parameter int SETUP_CLKS = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [7:0] rdata,
  input logic       cs_n,
  input logic       sck,
  input logic       mosi
);
  localparam int HW = $clog2(HALF_CLKS + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)
      hi_cnt <= '0;
    else if (sck)
      hi_cnt <= hi_cnt + HW'(1);
    else
      hi_cnt <= '0;
  end

  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);
  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));
  // R3
  cs_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> !sck);
  // R4
  high_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sck) |-> (hi_cnt == HW'(HALF_CLKS)));
  // R5
  mosi_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !mosi);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && cs_n));
  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rdata));
  // R9
  busy_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !cs_n) |=> busy);
endmodule

bind spi_reg_host spi_reg_host_chk #(
  .HALF_CLKS  (HALF_CLKS),
  .SETUP_CLKS (SETUP_CLKS)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .rdata (rdata),
  .cs_n  (cs_n),
  .sck   (sck),
  .mosi  (mosi)
);

// File: tb/sim_spi_reg_host.sv
`timescale 1ns/1ps
module sim_spi_reg_host;
  localparam int HALF  = 2;
  localparam int SETUP = 3;
  localparam longint PER = 10;

  typedef struct packed {
    logic [15:0] frame;
    logic [7:0]  rd;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, req_read = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic busy, done, cs_n, sck, mosi;
  logic [7:0] rdata;
  logic miso = 1'b0;

  int checks = 0, fails = 0;
  exp_t q[$];
  logic [7:0] last_rd = 8'h00;

  // peripheral model state
  logic [15:0] slave_word = '0, tx_sh = '0, rx_sh = '0, got_frame = '0;
  int nrise = 0, nframes = 0;
  logic in_frame = 1'b0, bad_half = 1'b0;
  longint t_csf = 0, t_first = 0, t_lastfall = 0, t_csr = 0, t_edge = 0;

  always #5 clk = ~clk;

  spi_reg_host #(.HALF_CLKS(HALF), .SETUP_CLKS(SETUP)) u0 (
    .clk(clk), .rst(rst), .start(start), .req_read(req_read),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // peripheral model: MISO changes on cs fall and on sck falls only
  always @(negedge cs_n) if (!rst) begin
    in_frame = 1'b1;
    nframes++;
    t_csf = $time;
    tx_sh = slave_word;
    rx_sh = '0;
    nrise = 0;
    bad_half = 1'b0;
    miso = tx_sh[15];
    // R3: MOSI already carries frame bit 15 at cs fall
    chk(mosi === q[0].frame[15] && sck === 1'b0, "R3 cs-fall mosi/sck",
        {30'd0, sck, mosi}, {31'd0, q[0].frame[15]});
  end

  always @(posedge sck) if (in_frame) begin
    rx_sh = {rx_sh[14:0], mosi};
    nrise++;
    if (nrise == 1) t_first = $time;
    else if ($time - t_edge != HALF * PER) bad_half = 1'b1;
    t_edge = $time;
  end

  always @(negedge sck) if (in_frame) begin
    if ($time - t_edge != HALF * PER) bad_half = 1'b1;
    t_edge = $time;
    t_lastfall = $time;
    tx_sh = {tx_sh[14:0], 1'b0};
    miso = tx_sh[15];
  end

  always @(posedge cs_n) if (in_frame) begin
    in_frame = 1'b0;
    t_csr = $time;
    got_frame = rx_sh;
  end

  // scoreboard monitor
  always @(negedge clk) if (!rst && done) begin
    exp_t e;
    if (q.size() == 0) begin
      chk(1'b0, "R6 unexpected done", 1, 0);
    end else begin
      e = q.pop_front();
      // R1 frame received by the peripheral
      chk(got_frame === e.frame, "R1 frame", {16'd0, got_frame}, {16'd0, e.frame});
      // R7 / R8 returned byte
      chk(rdata === e.rd, "R7 R8 rdata", {24'd0, rdata}, {24'd0, e.rd});
      // R4 rising edges and phase lengths
      chk(nrise == 16, "R4 rise count", nrise, 16);
      chk(!bad_half, "R4 half period", {31'd0, bad_half}, 0);
      // R3 setup before first rise
      chk(t_first - t_csf == SETUP * PER, "R3 setup",
          32'(t_first - t_csf), 32'(SETUP * PER));
      // R5 hold after last fall, mosi back to 0
      chk(t_csr - t_lastfall == SETUP * PER, "R5 hold",
          32'(t_csr - t_lastfall), 32'(SETUP * PER));
      chk(mosi === 1'b0, "R5 mosi idle", {31'd0, mosi}, 0);
      // R6 gap and busy
      chk($time - 5 - t_csr == 2 * SETUP * PER, "R6 gap",
          32'($time - 5 - t_csr), 32'(2 * SETUP * PER));
      chk(busy === 1'b0, "R6 busy low at done", {31'd0, busy}, 0);
    end
  end

  task automatic txn(input bit rd, input logic [6:0] a, input logic [7:0] wd,
                     input logic [15:0] sw, input bit inject);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    slave_word = sw;
    e.frame = {rd, a, wd};
    if (rd) last_rd = sw[7:0];   // R7: low byte of captured bits only
    e.rd = last_rd;              // R8: writes keep rdata
    q.push_back(e);
    start = 1'b1; req_read = rd; req_addr = a; req_wdata = wd;
    @(negedge clk);
    start = 1'b0; req_read = ~rd; req_addr = ~a; req_wdata = ~wd;
    if (inject) begin
      // R9: strobe during busy must be dropped
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    @(posedge done);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state while held
    chk({cs_n, sck, mosi, busy, done} === 5'b10000 && rdata === 8'h00,
        "R10 reset held", {19'd0, cs_n, sck, mosi, busy, done, rdata}, 32'h1000);
    rst = 1'b0;
    @(negedge clk);
    chk({cs_n, sck, mosi, busy, done} === 5'b10000 && rdata === 8'h00,
        "R10 after release", {19'd0, cs_n, sck, mosi, busy, done, rdata}, 32'h1000);

    txn(1'b0, 7'h00, 8'hFF, 16'hFFFF, 1'b0);
    txn(1'b1, 7'h02, 8'h00, 16'hA53C, 1'b0);   // R7 upper byte ignored -> 0x3C
    txn(1'b0, 7'h01, 8'h55, 16'h00C3, 1'b0);   // R8 write keeps 0x3C
    txn(1'b1, 7'h7F, 8'hAA, 16'h5AC5, 1'b1);   // R9 injected strobe
    txn(1'b1, 7'h15, 8'h81, 16'hFF00, 1'b0);
    txn(1'b0, 7'h2A, 8'h69, 16'h1234, 1'b1);   // R9 on a write

    // R9 no extra frames from injected strobes
    repeat (40) @(negedge clk);
    chk(nframes == 6, "R9 frame count", nframes, 6);
    chk(busy === 1'b0 && cs_n === 1'b1, "R9 idle after stray strobe",
        {30'd0, busy, cs_n}, 1);
    chk(q.size() == 0, "R6 all done pulses seen", q.size(), 0);
    // R8 rdata held long after last done
    chk(rdata === 8'h00, "R8 rdata hold", {24'd0, rdata}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule